// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a simple parallel host bus and the controller of an on-chip flash array. The host issues commands by writing opcode bytes on the bus. Program and erase requests take two bus writes. The first write is a leading opcode, and the second write either carries the payload or is a confirm code that selects the exact operation. Once a sequence is complete, the block fires a one-cycle launch pulse on a backend port. The pulse carries an operation kind, an address and a data byte. The block then waits for the backend to report completion and pass or fail.

The block keeps an 8-bit status byte and mirrors its ready bit on a ready/busy pin. When an operation is launched, host reads switch from array contents to the status byte. Reads stay in that mode after the operation completes, until the host writes the read-array opcode. Error flags are sticky. A dedicated clear command or reset clears them.

Top module: `fcmd_sequencer`

## Requirements
- R1: After reset the block is in array-read mode, the status byte is 0x80, `ready_busy` is 1 and `op_start` is 0. Array reads return `arr_rdata` for the address on `bus_addr`.
- R2: Writing 0x40 arms a program. The next write launches it with `op_type`=2'b00, and `op_addr`/`op_data` equal to that write's address and data.
- R3: Writing 0x20 and then 0x20 launches an erase of the whole array, with `op_type`=2'b01 and `op_addr`=0, `op_data`=0.
- R4: Writing 0x20 and then 0xD0 launches a single-block erase, with `op_type`=2'b10 and `op_data`=0. `op_addr` is the second write's address with its low `BLK_W` bits cleared.
- R5: `op_start` is high for exactly one cycle, in the cycle after the completing bus write.
- R6: `ready_busy` always equals status bit 7. It drops in the same cycle as `op_start` and rises in the cycle after the backend's `op_done` pulse.
- R7: Launching an operation switches reads to status mode. A read returns `{ready,0,erase_err,prog_err,4'b0}` (bit 7 ready, bit 5 erase error, bit 4 program error) one cycle after `bus_re`.
- R8: Status mode persists after completion. Only a 0xFF write in the idle state returns reads to array contents.
- R9: If `op_fail` is high with `op_done`, status bit 4 is set for a program and status bit 5 is set for either erase.
- R10: If 0x20 is followed by any code other than 0x20 or 0xD0, nothing is launched. Bits 4 and 5 are both set and reads switch to status mode.
- R11: While busy, bus writes launch nothing and leave the status byte and the read mode unchanged.
- R12: Error bits stay set across later successful operations. A 0x50 write in idle clears bits 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_re | input | 1 | Bus read strobe |
| bus_addr | input | AW | Bus address |
| bus_wdata | input | 8 | Bus write data / opcode |
| bus_rdata | output | 8 | Registered read data (array or status) |
| arr_addr | output | AW | Address presented to the array read port |
| arr_rdata | input | 8 | Array read data |
| ready_busy | output | 1 | 1 = ready, 0 = operation in progress |
| op_start | output | 1 | One-cycle launch pulse to the backend |
| op_type | output | 2 | 00 program, 01 erase all, 10 block erase |
| op_addr | output | AW | Target address or block base |
| op_data | output | 8 | Byte to program |
| op_done | input | 1 | Backend completion pulse |
| op_fail | input | 1 | Failure flag, valid with `op_done` |

## Verification
A bus write is registered at a clock edge. The resulting `op_start`, the falling `ready_busy` and the status-mode switch are all visible one cycle later, and an `op_done` pulse raises `ready_busy` one cycle after its edge. A read strobe returns data one edge later. The bench drives every strobe on a falling edge, lets one rising edge pass and samples at the next falling edge, so each check lands in the exact cycle its result is due. A reference model of the error flags and the read mode is updated from the requirements, not from the RTL. Random sequences of programs, erases, bad confirms, clears and array reads are checked against that model.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  typedef enum logic [1:0] {
    OP_PROG      = 2'b00,
    OP_ERASE_ALL = 2'b01,
    OP_ERASE_BLK = 2'b10
  } op_kind_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ARM_PROG,
    SEQ_ARM_ERASE,
    SEQ_BUSY
  } seq_state_e;

  localparam logic [7:0] CODE_PROG      = 8'h40;
  localparam logic [7:0] CODE_ERASE     = 8'h20;
  localparam logic [7:0] CODE_BLK_CONF  = 8'hD0;
  localparam logic [7:0] CODE_READ_ARR  = 8'hFF;
  localparam logic [7:0] CODE_CLR_STAT  = 8'h50;

  localparam int RDY_BIT  = 7;
  localparam int EERR_BIT = 5;
  localparam int PERR_BIT = 4;

  // Build the status byte from its three live flags.
  function automatic logic [7:0] pack_status(input logic rdy, input logic perr,
                                             input logic eerr);
    logic [7:0] s;
    s = 8'h00;
    s[RDY_BIT]  = rdy;
    s[EERR_BIT] = eerr;
    s[PERR_BIT] = perr;
    return s;
  endfunction

endpackage

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
  import fcmd_pkg::*;
#(
  parameter int AW    = 16,
  parameter int BLK_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          op_done,
  output logic          op_start,
  output logic [1:0]    op_type,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          evt_launch,
  output logic          evt_finish,
  output logic          evt_seq_err,
  output logic          evt_read_arr,
  output logic          evt_clr_stat,
  output logic          finish_is_prog
);

  // Base address of the block that holds a.
  function automatic logic [AW-1:0] blk_base(input logic [AW-1:0] a);
    logic [AW-1:0] m;
    m = '1;
    m = m << BLK_W;
    return a & m;
  endfunction

  seq_state_e    state_q, state_n;
  logic          start_q;
  op_kind_e      kind_q, kind_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [7:0]    data_q, data_n;

  always_comb begin
    state_n      = state_q;
    kind_n       = kind_q;
    addr_n       = addr_q;
    data_n       = data_q;
    evt_launch   = 1'b0;
    evt_seq_err  = 1'b0;
    evt_read_arr = 1'b0;
    evt_clr_stat = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (bus_we) begin
          unique case (bus_wdata)
            CODE_PROG:     state_n = SEQ_ARM_PROG;
            CODE_ERASE:    state_n = SEQ_ARM_ERASE;
            CODE_READ_ARR: evt_read_arr = 1'b1;
            CODE_CLR_STAT: evt_clr_stat = 1'b1;
            default:       state_n = SEQ_IDLE;
          endcase
        end
      end
      SEQ_ARM_PROG: begin
        if (bus_we) begin
          evt_launch = 1'b1;
          kind_n     = OP_PROG;
          addr_n     = bus_addr;
          data_n     = bus_wdata;
          state_n    = SEQ_BUSY;
        end
      end
      SEQ_ARM_ERASE: begin
        if (bus_we) begin
          if (bus_wdata == CODE_ERASE) begin
            evt_launch = 1'b1;
            kind_n     = OP_ERASE_ALL;
            addr_n     = '0;
            data_n     = 8'h00;
            state_n    = SEQ_BUSY;
          end else if (bus_wdata == CODE_BLK_CONF) begin
            evt_launch = 1'b1;
            kind_n     = OP_ERASE_BLK;
            addr_n     = blk_base(bus_addr);
            data_n     = 8'h00;
            state_n    = SEQ_BUSY;
          end else begin
            evt_seq_err = 1'b1;
            state_n     = SEQ_IDLE;
          end
        end
      end
      SEQ_BUSY: begin
        if (op_done) state_n = SEQ_IDLE;
      end
      default: state_n = SEQ_IDLE;
    endcase
  end

  assign evt_finish     = (state_q == SEQ_BUSY) && op_done;
  assign finish_is_prog = (kind_q == OP_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      start_q <= 1'b0;
      kind_q  <= OP_PROG;
      addr_q  <= '0;
      data_q  <= 8'h00;
    end else begin
      state_q <= state_n;
      start_q <= evt_launch;
      kind_q  <= kind_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
    end
  end

  assign op_start = start_q;
  assign op_type  = kind_q;
  assign op_addr  = addr_q;
  assign op_data  = data_q;

endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
  import fcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_launch,
  input  logic       evt_finish,
  input  logic       finish_is_prog,
  input  logic       op_fail,
  input  logic       evt_seq_err,
  input  logic       evt_read_arr,
  input  logic       evt_clr_stat,
  output logic [7:0] status_byte,
  output logic       stat_mode,
  output logic       ready
);

  logic rdy_q, perr_q, eerr_q, mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b1;
      perr_q <= 1'b0;
      eerr_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (evt_launch) begin
        rdy_q  <= 1'b0;
        mode_q <= 1'b1;
      end
      if (evt_finish) begin
        rdy_q <= 1'b1;
        if (op_fail) begin
          if (finish_is_prog) perr_q <= 1'b1;
          else                eerr_q <= 1'b1;
        end
      end
      if (evt_seq_err) begin
        perr_q <= 1'b1;
        eerr_q <= 1'b1;
        mode_q <= 1'b1;
      end
      if (evt_clr_stat) begin
        perr_q <= 1'b0;
        eerr_q <= 1'b0;
      end
      if (evt_read_arr) mode_q <= 1'b0;
    end
  end

  assign status_byte = pack_status(rdy_q, perr_q, eerr_q);
  assign stat_mode   = mode_q;
  assign ready       = rdy_q;

endmodule

// File: rtl/fcmd_rdpath.sv
module fcmd_rdpath #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_re,
  input  logic          stat_mode,
  input  logic [DW-1:0] status_byte,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] bus_rdata
);

  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_re) rdata_q <= stat_mode ? status_byte : arr_rdata;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/fcmd_sequencer.sv
module fcmd_sequencer
  import fcmd_pkg::*;
#(
  parameter int AW    = 16,
  parameter int BLK_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic [AW-1:0] arr_addr,
  input  logic [7:0]    arr_rdata,
  output logic          ready_busy,
  output logic          op_start,
  output logic [1:0]    op_type,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  input  logic          op_done,
  input  logic          op_fail
);

  // Named internal events, visible to the bound checker.
  logic       evt_launch, evt_finish, evt_seq_err;
  logic       evt_read_arr, evt_clr_stat, finish_is_prog;
  logic [7:0] status_byte;
  logic       stat_mode;

  fcmd_decoder #(.AW(AW), .BLK_W(BLK_W)) u_dec (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_we         (bus_we),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .op_done        (op_done),
    .op_start       (op_start),
    .op_type        (op_type),
    .op_addr        (op_addr),
    .op_data        (op_data),
    .evt_launch     (evt_launch),
    .evt_finish     (evt_finish),
    .evt_seq_err    (evt_seq_err),
    .evt_read_arr   (evt_read_arr),
    .evt_clr_stat   (evt_clr_stat),
    .finish_is_prog (finish_is_prog)
  );

  fcmd_status u_stat (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_launch     (evt_launch),
    .evt_finish     (evt_finish),
    .finish_is_prog (finish_is_prog),
    .op_fail        (op_fail),
    .evt_seq_err    (evt_seq_err),
    .evt_read_arr   (evt_read_arr),
    .evt_clr_stat   (evt_clr_stat),
    .status_byte    (status_byte),
    .stat_mode      (stat_mode),
    .ready          (ready_busy)
  );

  fcmd_rdpath #(.DW(8)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_re      (bus_re),
    .stat_mode   (stat_mode),
    .status_byte (status_byte),
    .arr_rdata   (arr_rdata),
    .bus_rdata   (bus_rdata)
  );

  assign arr_addr = bus_addr;

endmodule

// File: rtl/fcmd_sequencer_chk.sv
module fcmd_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_start,
  input logic       ready_busy,
  input logic [7:0] status_byte,
  input logic       stat_mode,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic       evt_seq_err
);

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);

  // R6
  rdy_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_busy == status_byte[7]);

  // R7
  start_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> (!ready_busy && stat_mode));

  // R11
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_busy |=> !op_start);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_mode) |-> $past(bus_we && (bus_wdata == 8'hFF)));

  // R10
  seq_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_seq_err |=> (status_byte[5:4] == 2'b11 && !op_start && stat_mode));

endmodule

bind fcmd_sequencer fcmd_sequencer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_start    (op_start),
  .ready_busy  (ready_busy),
  .status_byte (status_byte),
  .stat_mode   (stat_mode),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .evt_seq_err (evt_seq_err)
);

// File: tb/sim_fcmd_sequencer.sv
`timescale 1ns/1ps
module sim_fcmd_sequencer;

  localparam int AW    = 16;
  localparam int BLK_W = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0, bus_re = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = 8'h00;
  logic [7:0]    bus_rdata;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_rdata;
  logic          ready_busy, op_start;
  logic [1:0]    op_type;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;
  logic          op_done = 1'b0, op_fail = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // Bench model of the block state
  bit m_perr = 0, m_eerr = 0, m_mode = 0;

  always #2 clk = ~clk;

  // array content model: a function of the address
  assign arr_rdata = arr_addr[7:0] ^ 8'h5A;

  fcmd_sequencer #(.AW(AW), .BLK_W(BLK_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata), .ready_busy(ready_busy),
    .op_start(op_start), .op_type(op_type), .op_addr(op_addr),
    .op_data(op_data), .op_done(op_done), .op_fail(op_fail)
  );

  function automatic logic [7:0] exp_status(bit rdy, bit pe, bit ee);
    return (rdy ? 8'h80 : 8'h00) | (ee ? 8'h20 : 8'h00) | (pe ? 8'h10 : 8'h00);
  endfunction

  function automatic logic [AW-1:0] exp_blk(logic [AW-1:0] a);
    return (a >> BLK_W) << BLK_W;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [AW-1:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bread_chk(input string req, input logic [AW-1:0] a, input bit rdy);
    logic [7:0] e;
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    e = m_mode ? exp_status(rdy, m_perr, m_eerr) : (a[7:0] ^ 8'h5A);
    chk(req, bus_rdata, e);
  endtask

  // kind: 0 program, 1 erase all, 2 block erase
  task automatic do_op(input int kind, input logic [AW-1:0] a, input logic [7:0] d,
                       input bit fail, input int lat);
    string rq;
    rq = (kind == 0) ? "R2" : (kind == 1) ? "R3" : "R4";
    if (kind == 0) begin
      bwrite(16'h0000, 8'h40);
      bwrite(a, d);
    end else begin
      bwrite(16'h0000, 8'h20);
      bwrite(a, (kind == 1) ? 8'h20 : 8'hD0);
    end
    chk({rq, " start"}, op_start, 1);
    chk({rq, " type"}, op_type, kind[1:0]);
    chk({rq, " addr"}, op_addr, (kind == 0) ? a : (kind == 1) ? '0 : exp_blk(a));
    chk({rq, " data"}, op_data, (kind == 0) ? d : 8'h00);
    chk("R6 busy with start", ready_busy, 0);
    m_mode = 1;
    // a write while busy must be ignored
    bwrite(a, 8'h40);
    chk("R5 one-cycle start", op_start, 0);
    bwrite(a, 8'hFF);
    chk("R11 busy write no start", op_start, 0);
    bread_chk("R7 status while busy", a, 0);
    chk("R11 still busy", ready_busy, 0);
    repeat (lat) @(negedge clk);
    op_done = 1'b1; op_fail = fail;
    @(negedge clk);
    op_done = 1'b0; op_fail = 1'b0;
    chk("R6 ready after done", ready_busy, 1);
    if (fail) begin
      if (kind == 0) m_perr = 1; else m_eerr = 1;
    end
    bread_chk(fail ? "R9 fail status" : "R8 status persists", a, 1);
  endtask

  task automatic do_seq_err(input logic [7:0] bad);
    bwrite(16'h0000, 8'h20);
    bwrite(16'h1234, bad);
    chk("R10 no start", op_start, 0);
    chk("R10 ready", ready_busy, 1);
    m_perr = 1; m_eerr = 1; m_mode = 1;
    bread_chk("R10 error status", 16'h0010, 1);
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] bad;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 ready at reset", ready_busy, 1);
    chk("R1 no start at reset", op_start, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", ready_busy, 1);
    bread_chk("R1 array read", 16'h00C3, 1);

    // directed corner cases
    do_op(0, 16'hABCD, 8'h3C, 0, 3);
    bwrite(16'h0, 8'hFF); m_mode = 0;
    bread_chk("R8 back to array", 16'h0077, 1);
    do_op(2, 16'hFFFF, 8'h00, 1, 0);
    do_op(1, 16'h0420, 8'h00, 0, 5);
    bread_chk("R12 sticky after good op", 16'h0001, 1);
    bwrite(16'h0, 8'h50); m_perr = 0; m_eerr = 0;
    bread_chk("R12 clear", 16'h0002, 1);
    do_op(0, 16'h0001, 8'hFF, 1, 2);
    do_seq_err(8'hFF);
    bwrite(16'h0, 8'h50); m_perr = 0; m_eerr = 0;
    bwrite(16'h0, 8'hFF); m_mode = 0;
    do_seq_err(8'h40);
    bwrite(16'h0, 8'h33);
    chk("R11 unknown code no start", op_start, 0);
    bread_chk("R10 unknown code ignored", 16'h0003, 1);

    // constrained random
    for (int i = 0; i < 60; i++) begin
      int sel;
      sel = $urandom % 6;
      case (sel)
        0, 1, 2: do_op(sel, AW'($urandom), 8'($urandom), ($urandom % 3) == 0,
                       $urandom % 6);
        3: begin
          bad = 8'($urandom);
          if (bad == 8'h20 || bad == 8'hD0) bad = 8'h11;
          do_seq_err(bad);
        end
        4: begin
          bwrite(16'h0, 8'hFF); m_mode = 0;
          bread_chk("R8 random array read", AW'($urandom), 1);
        end
        default: begin
          bwrite(16'h0, 8'h50); m_perr = 0; m_eerr = 0;
          bread_chk("R12 random clear", AW'($urandom), 1);
        end
      endcase
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule